// File: doc/BRIEF.md
# Control register file with test shift path

This block gives the rest of a multi-channel time digitiser a small, byte-wide control interface. It offers four locations behind a 2-bit address, a chip select, a read/write select and an 8-bit data path. Location 0 holds the mode and test controls. Locations 1 and 2 are the read and write pointer counters of the hit memory. Location 3 holds a test data word and the two serial test bits. The bus pins are active high inside this block; any pad inversion is done outside it.

Both pointers are live counters. Advance strobes from the recording and readout logic step them, and a bus write loads them. For silicon test, location 3 can do two things. It can stand in for one encoder word on the way into the hit memory while it captures that encoder's output. It can also push one serial bit into a chosen encoder register at the end of each access to location 3.

Top module: `csr_regfile`

## Requirements
- R1: After reset, `ctl_bits`, `rd_ptr` and `wr_ptr` are 0, and reads of locations 0, 1 and 2 return 0x00. A read of location 3 returns 0x00 while the selected `scan_out_in` bit is 0.
- R2: An access is latched on each clock edge that sees `bus_cs` high. A write (`bus_rnw`=0) commits on the first clock edge that sees `bus_cs` low after the access. A write to location 0 sets `ctl_bits` to the written byte. The fields are: bit 0 selects the falling-edge word, bits 2..1 select the test channel, bit 3 is a spare, bit 4 enables the read pointer step on `async_rd_done`, bit 5 stops the read pointer from following `wr_adv`, bit 6 selects memory test, and bit 7 enables the shift.
- R3: `bus_rdata_oe` is 1 exactly while `bus_cs`=1 and `bus_rnw`=1, and `bus_rdata` is 0x00 whenever `bus_rdata_oe` is 0. While it is driven, `bus_rdata` shows the location given by the live `bus_addr`.
- R4: A write to location 1 or 2 loads bits 6..0 into the read or write pointer and ignores bit 7. A read of location 1 or 2 returns the present count with bit 7 at 0.
- R5: The write pointer steps by one on each clock edge with `wr_adv`=1, and wraps from 127 to 0.
- R6: The read pointer steps by one on an edge with `wr_adv`=1 unless control bit 5 is set. It also steps on an edge with `async_rd_done`=1 when control bit 4 is set. Otherwise it holds.
- R7: A bus load of a pointer takes priority over that pointer's step on the same edge.
- R8: A write to location 3 stores bit 6 (serial-in) and bits 5..0 (test word), and ignores bit 7. A read of location 3 returns `scan_out_in` of the selected test channel in bit 7, serial-in in bit 6 and the test word in bits 5..0.
- R9: When control bit 7 is set, at the end of every access to location 3 (read or write), `shift_pulse` is high for that one cycle on the bit of the selected test channel only. In that cycle `shift_bit` carries the serial-in value the access leaves behind: the written bit 6 for a write, the stored bit for a read. At all other times `shift_pulse` is 0.
- R10: With control bit 6 clear, `mem_rise`/`mem_fall` equal `enc_rise`/`enc_fall`. With it set, the 6-bit word of the selected channel in the selected edge bus (bit 0: 0 rising, 1 falling) is replaced by the test word, and all other words pass through.
- R11: While control bit 6 is set, the test word loads the selected encoder word on every clock edge. A bus write to location 3 that commits on the same edge wins over this capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs | input | 1 | Chip select, active high |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_addr | input | 2 | Register location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not driven |
| bus_rdata_oe | output | 1 | Read data valid / drive enable |
| wr_adv | input | 1 | Write pointer advance strobe from the recording logic |
| async_rd_done | input | 1 | End of one asynchronous read strobe |
| ctl_bits | output | 8 | Control byte to the buffer logic |
| rd_ptr | output | 7 | Read pointer count |
| wr_ptr | output | 7 | Write pointer count |
| enc_rise | input | 24 | Rising-edge encoder words, 6 bits per channel, channel 0 lowest |
| enc_fall | input | 24 | Falling-edge encoder words, same packing |
| mem_rise | output | 24 | Rising-edge words to the hit memory |
| mem_fall | output | 24 | Falling-edge words to the hit memory |
| scan_out_in | input | 4 | Serial outputs of the encoder registers, one per channel |
| shift_pulse | output | 4 | One-hot shift strobe to the encoder registers |
| shift_bit | output | 1 | Serial bit to shift in |

## Verification
Read data and its drive enable are combinational, so they are due in the same cycle that chip select and read are applied. A write shows in `ctl_bits`, the pointers or the test word one cycle after chip select drops, on the edge that sees it low. The shift strobe is due in the cycle between chip select dropping and that edge. Pointer steps and test-word captures are due one edge after their strobe. The driver changes inputs just after a rising edge and queues what each result should be in that cycle, and the monitor compares at the following falling edge. Because of this, every check samples after exactly the register stages counted above.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    LOC_CTL  = 2'd0,
    LOC_RPTR = 2'd1,
    LOC_WPTR = 2'd2,
    LOC_TEST = 2'd3
  } csr_loc_e;

  // Field order is decoded by the buffer logic; keep it fixed.
  typedef struct packed {
    logic       shift_en;
    logic       mem_test;
    logic       rp_nofollow;
    logic       rp_auto;
    logic       spare;
    logic [1:0] tsel_ch;
    logic       tsel_fall;
  } ctl_t;
endpackage

// File: rtl/csr_bus_if.sv
module csr_bus_if #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_rnw,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          acc_end,
  output logic          acc_rnw,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata
);
  logic cs_q;
  logic cap_en;

  always_comb begin
    cap_en  = bus_cs;
    acc_end = cs_q & ~bus_cs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b0;
      acc_rnw   <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      cs_q <= bus_cs;
      if (cap_en) begin
        acc_rnw   <= bus_rnw;
        acc_addr  <= bus_addr;
        acc_wdata <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/csr_ptr_counter.sv
module csr_ptr_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld | inc;
    if (ld) cnt_d = ld_val;
    else    cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/csr_test_path.sv
module csr_test_path
  import csr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WORD_W = 6,
  parameter int CH_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctl_t                  ctl,
  input  logic                  tdr_wr,
  input  logic [WORD_W-1:0]     tdr_wval,
  input  logic                  shift_req,
  input  logic                  shift_val,
  input  logic [NCH*WORD_W-1:0] enc_rise,
  input  logic [NCH*WORD_W-1:0] enc_fall,
  output logic [NCH*WORD_W-1:0] mem_rise,
  output logic [NCH*WORD_W-1:0] mem_fall,
  output logic [WORD_W-1:0]     tdr,
  output logic [NCH-1:0]        shift_pulse,
  output logic                  shift_bit
);
  logic [CH_W-1:0]   tch;
  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] tdr_d;
  logic              tdr_en;

  always_comb begin
    tch      = ctl.tsel_ch[CH_W-1:0];
    sel_word = ctl.tsel_fall ? enc_fall[tch*WORD_W +: WORD_W]
                             : enc_rise[tch*WORD_W +: WORD_W];
    tdr_en   = tdr_wr | ctl.mem_test;
    tdr_d    = tdr_wr ? tdr_wval : sel_word;
    shift_bit = shift_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tdr <= '0;
    else if (tdr_en) tdr <= tdr_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = ctl.mem_test && (tch == CH_W'(c));
    assign mem_rise[c*WORD_W +: WORD_W] = (hit && !ctl.tsel_fall) ? tdr : enc_rise[c*WORD_W +: WORD_W];
    assign mem_fall[c*WORD_W +: WORD_W] = (hit &&  ctl.tsel_fall) ? tdr : enc_fall[c*WORD_W +: WORD_W];
    assign shift_pulse[c] = shift_req && ctl.shift_en && (tch == CH_W'(c));
  end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PTR_W  = 7,
  parameter int WORD_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_cs,
  input  logic                  bus_rnw,
  input  logic [1:0]            bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  bus_rdata_oe,
  input  logic                  wr_adv,
  input  logic                  async_rd_done,
  output logic [7:0]            ctl_bits,
  output logic [PTR_W-1:0]      rd_ptr,
  output logic [PTR_W-1:0]      wr_ptr,
  input  logic [NCH*WORD_W-1:0] enc_rise,
  input  logic [NCH*WORD_W-1:0] enc_fall,
  output logic [NCH*WORD_W-1:0] mem_rise,
  output logic [NCH*WORD_W-1:0] mem_fall,
  input  logic [NCH-1:0]        scan_out_in,
  output logic [NCH-1:0]        shift_pulse,
  output logic                  shift_bit
);
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SIN_BIT = BUS_W - 2;

  logic             rst_meta, rst_sync;
  logic             acc_end, acc_rnw;
  logic [1:0]       acc_addr;
  logic [BUS_W-1:0] acc_wdata;
  logic             wr_commit;
  logic             ctl_ld, rp_ld, wp_ld, tst_ld;
  logic             rp_inc;
  logic [PTR_W-1:0] ld_val;
  ctl_t             ctl_q, ctl_d;
  logic             sin_q, sin_d;
  logic [WORD_W-1:0] tdr;
  logic             shift_req, shift_val;
  logic [CH_W-1:0]  tch;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  csr_bus_if #(.AW(ADDR_W), .DW(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_sync),
    .bus_cs(bus_cs), .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .acc_end(acc_end), .acc_rnw(acc_rnw), .acc_addr(acc_addr), .acc_wdata(acc_wdata)
  );

  always_comb begin
    wr_commit = acc_end & ~acc_rnw;
    ctl_ld    = wr_commit && (acc_addr == LOC_CTL);
    rp_ld     = wr_commit && (acc_addr == LOC_RPTR);
    wp_ld     = wr_commit && (acc_addr == LOC_WPTR);
    tst_ld    = wr_commit && (acc_addr == LOC_TEST);
    ld_val    = acc_wdata[PTR_W-1:0];
    rp_inc    = (wr_adv & ~ctl_q.rp_nofollow) | (async_rd_done & ctl_q.rp_auto);
    ctl_d     = ctl_ld ? ctl_t'(acc_wdata) : ctl_q;
    sin_d     = tst_ld ? acc_wdata[SIN_BIT] : sin_q;
    shift_req = acc_end && (acc_addr == LOC_TEST);
    shift_val = acc_rnw ? sin_q : acc_wdata[SIN_BIT];
    tch       = ctl_q.tsel_ch[CH_W-1:0];
    ctl_bits  = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ctl_q <= '0;
      sin_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      sin_q <= sin_d;
    end
  end

  csr_ptr_counter #(.W(PTR_W)) u_rptr (
    .clk(clk), .rst_n(rst_sync), .ld(rp_ld), .ld_val(ld_val), .inc(rp_inc), .cnt(rd_ptr)
  );

  csr_ptr_counter #(.W(PTR_W)) u_wptr (
    .clk(clk), .rst_n(rst_sync), .ld(wp_ld), .ld_val(ld_val), .inc(wr_adv), .cnt(wr_ptr)
  );

  csr_test_path #(.NCH(NCH), .WORD_W(WORD_W), .CH_W(CH_W)) u_test (
    .clk(clk), .rst_n(rst_sync), .ctl(ctl_q),
    .tdr_wr(tst_ld), .tdr_wval(acc_wdata[WORD_W-1:0]),
    .shift_req(shift_req), .shift_val(shift_val),
    .enc_rise(enc_rise), .enc_fall(enc_fall),
    .mem_rise(mem_rise), .mem_fall(mem_fall),
    .tdr(tdr), .shift_pulse(shift_pulse), .shift_bit(shift_bit)
  );

  // Read path: live address, driven only during a read access.
  always_comb begin
    bus_rdata_oe = bus_cs & bus_rnw;
    bus_rdata    = '0;
    if (bus_rdata_oe) begin
      case (csr_loc_e'(bus_addr))
        LOC_CTL:  bus_rdata = ctl_q;
        LOC_RPTR: bus_rdata[PTR_W-1:0] = rd_ptr;
        LOC_WPTR: bus_rdata[PTR_W-1:0] = wr_ptr;
        default: begin
          bus_rdata[WORD_W-1:0] = tdr;
          bus_rdata[SIN_BIT]    = sin_q;
          bus_rdata[BUS_W-1]    = scan_out_in[tch];
        end
      endcase
    end
  end
endmodule

// File: rtl/csr_regfile_chk.sv
module csr_regfile_chk #(
  parameter int PTR_W = 7,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rst_sync,
  input logic [7:0]       bus_rdata,
  input logic             bus_rdata_oe,
  input logic             wr_adv,
  input logic             wp_ld,
  input logic [PTR_W-1:0] ld_val,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [NCH-1:0]   shift_pulse,
  input logic [7:0]       ctl_bits
);
  // R3
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !bus_rdata_oe |-> (bus_rdata == 8'h00));

  // R5
  wp_step_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_adv && !wp_ld) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

  // R7
  ld_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    wp_ld |=> (wr_ptr == $past(ld_val)));

  // R9
  shift_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(shift_pulse));

  // R9
  shift_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (|shift_pulse) |-> ctl_bits[7]);
endmodule

bind csr_regfile csr_regfile_chk #(.PTR_W(PTR_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_sync(rst_sync), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
  .wr_adv(wr_adv), .wp_ld(wp_ld), .ld_val(ld_val), .wr_ptr(wr_ptr),
  .shift_pulse(shift_pulse), .ctl_bits(ctl_bits)
);

// File: tb/tb_csr_regfile.sv
module tb_csr_regfile;
  typedef enum int {S_RDATA, S_OE, S_CTL, S_RP, S_WP, S_SPULSE, S_SBIT, S_MRISE, S_MFALL} sel_e;
  typedef struct {
    string       req;
    sel_e        sel;
    logic [31:0] val;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cs, bus_rnw, wr_adv, async_rd_done;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, ctl_bits;
  logic        bus_rdata_oe, shift_bit;
  logic [6:0]  rd_ptr, wr_ptr;
  logic [23:0] enc_rise, enc_fall, mem_rise, mem_fall;
  logic [3:0]  scan_out_in, shift_pulse;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #4 clk = ~clk;

  csr_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .wr_adv(wr_adv), .async_rd_done(async_rd_done), .ctl_bits(ctl_bits),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .enc_rise(enc_rise), .enc_fall(enc_fall),
    .mem_rise(mem_rise), .mem_fall(mem_fall), .scan_out_in(scan_out_in),
    .shift_pulse(shift_pulse), .shift_bit(shift_bit)
  );

  function automatic logic [31:0] pick(sel_e s);
    case (s)
      S_RDATA:  return {24'h0, bus_rdata};
      S_OE:     return {31'h0, bus_rdata_oe};
      S_CTL:    return {24'h0, ctl_bits};
      S_RP:     return {25'h0, rd_ptr};
      S_WP:     return {25'h0, wr_ptr};
      S_SPULSE: return {28'h0, shift_pulse};
      S_SBIT:   return {31'h0, shift_bit};
      S_MRISE:  return {8'h0, mem_rise};
      default:  return {8'h0, mem_fall};
    endcase
  endfunction

  // Monitor: compare everything queued for this cycle.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      act = pick(e.sel);
      n_cmp++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s sel=%s actual=0x%0h expected=0x%0h", e.req, e.sel.name(), act, e.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic want(string r, sel_e s, logic [31:0] v);
    q.push_back('{r, s, v});
  endtask

  function automatic logic [23:0] splice(logic [23:0] v, int ch, logic [5:0] w);
    logic [23:0] r;
    r = v;
    r[ch*6 +: 6] = w;
    return r;
  endfunction

  task automatic bus_write(logic [1:0] a, logic [7:0] d, string r, logic [3:0] sp, logic sb);
    tick(); bus_cs = 1; bus_rnw = 0; bus_addr = a; bus_wdata = d;
    tick(); bus_cs = 0;
    want(r, S_SPULSE, {28'h0, sp});
    if (sp != 0) want(r, S_SBIT, {31'h0, sb});
    tick();
  endtask

  task automatic bus_read(logic [1:0] a, logic [7:0] x, string r, logic [3:0] sp, logic sb);
    tick(); bus_cs = 1; bus_rnw = 1; bus_addr = a;
    want(r, S_OE, 1); want(r, S_RDATA, {24'h0, x});
    tick(); bus_cs = 0;
    want("R3", S_OE, 0); want("R3", S_RDATA, 0);
    want(r, S_SPULSE, {28'h0, sp});
    if (sp != 0) want(r, S_SBIT, {31'h0, sb});
    tick();
  endtask

  task automatic pulse_adv(bit wa, bit ad);
    tick(); wr_adv = wa; async_rd_done = ad;
    tick(); wr_adv = 0; async_rd_done = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_cs = 0; bus_rnw = 1; bus_addr = 0; bus_wdata = 0;
    wr_adv = 0; async_rd_done = 0; scan_out_in = 0;
    enc_rise = 24'h123456; enc_fall = 24'hABCDEF;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    want("R1", S_CTL, 0); want("R1", S_RP, 0); want("R1", S_WP, 0); want("R3", S_OE, 0);
    for (int a = 0; a < 4; a++) bus_read(2'(a), 8'h00, "R1", 4'h0, 0);

    // R2 control write, R3 readback
    bus_write(2'd0, 8'h12, "R2", 4'h0, 0);
    want("R2", S_CTL, 8'h12);
    bus_read(2'd0, 8'h12, "R3", 4'h0, 0);

    // R4 pointer loads, bit 7 ignored
    bus_write(2'd1, 8'hFF, "R4", 4'h0, 0);
    want("R4", S_RP, 7'h7F);
    bus_read(2'd1, 8'h7F, "R4", 4'h0, 0);
    bus_write(2'd2, 8'h85, "R4", 4'h0, 0);
    bus_read(2'd2, 8'h05, "R4", 4'h0, 0);

    // R5 / R6 advance with follow enabled; read pointer wraps
    pulse_adv(1, 0);
    want("R5", S_WP, 7'd6); want("R6", S_RP, 7'd0);
    bus_write(2'd2, 8'h7F, "R5", 4'h0, 0);
    pulse_adv(1, 0);
    want("R5", S_WP, 7'd0); want("R6", S_RP, 7'd1);

    // R6 follow disabled, async step enabled then disabled
    bus_write(2'd0, 8'h32, "R6", 4'h0, 0);
    pulse_adv(1, 0);
    want("R6", S_WP, 7'd1); want("R6", S_RP, 7'd1);
    pulse_adv(0, 1);
    want("R6", S_RP, 7'd2);
    bus_write(2'd0, 8'h22, "R6", 4'h0, 0);
    pulse_adv(0, 1);
    want("R6", S_RP, 7'd2);

    // R7 load beats step on the same edge
    tick(); bus_cs = 1; bus_rnw = 0; bus_addr = 2'd2; bus_wdata = 8'h33;
    tick(); bus_cs = 0; wr_adv = 1;
    tick(); wr_adv = 0;
    want("R7", S_WP, 7'h33); want("R7", S_RP, 7'd2);

    // R8 test location store and readback
    bus_write(2'd0, 8'h02, "R8", 4'h0, 0);
    scan_out_in = 4'b0010;
    bus_write(2'd3, 8'hFF, "R8", 4'h0, 0);
    bus_read(2'd3, 8'hFF, "R8", 4'h0, 0);
    bus_write(2'd3, 8'h15, "R8", 4'h0, 0);
    bus_read(2'd3, 8'h95, "R8", 4'h0, 0);

    // R9 shift strobes
    bus_write(2'd0, 8'h82, "R9", 4'h0, 0);
    bus_write(2'd3, 8'h40, "R9", 4'b0010, 1);
    bus_read(2'd3, 8'hC0, "R9", 4'b0010, 1);
    bus_write(2'd3, 8'h00, "R9", 4'b0010, 0);
    bus_read(2'd1, 8'h02, "R9", 4'h0, 0);
    scan_out_in = 4'b0000;

    // R10 pass-through, then substitution on falling bus, channel 2
    want("R10", S_MRISE, enc_rise); want("R10", S_MFALL, enc_fall);
    bus_write(2'd0, 8'h45, "R10", 4'h0, 0);
    want("R10", S_MFALL, splice(enc_fall, 2, 6'h00)); want("R10", S_MRISE, enc_rise);
    tick();
    want("R11", S_MFALL, enc_fall);

    // R11 bus write wins over capture, capture resumes next edge
    bus_write(2'd3, 8'h15, "R11", 4'h0, 0);
    want("R11", S_MFALL, splice(enc_fall, 2, 6'h15));
    tick();
    want("R11", S_MFALL, enc_fall);
    bus_read(2'd3, 8'h3C, "R11", 4'h0, 0);

    // R10 rising bus selection
    bus_write(2'd0, 8'h44, "R10", 4'h0, 0);
    want("R10", S_MRISE, splice(enc_rise, 2, 6'h3C)); want("R10", S_MFALL, enc_fall);
    tick();
    want("R11", S_MRISE, enc_rise);

    tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule